// File: doc/BRIEF.md
# Per-Process Page Translation Unit

This block sits between an 8-bit processor's 16-bit address bus and the system memory bus. It replaces the top four address bits with a physical page drawn from a small lookup table. The table is indexed by the active process number together with the CPU page. Each process therefore sees its own private physical pages, including the zero page and stack page, which sit at fixed CPU addresses. The device selects (RAM, ROM, peripheral, table port) are decoded from the translated entry, not from the raw CPU address.

A privilege flag comes out of reset set. While it is set, the table is bypassed by a fixed map. That map places the supervisor's private low memory at CPU page 0, gives identity RAM pages in the middle, a peripheral page, a table-programming port page and a ROM page. Only the supervisor can program the table or load the write-only process register, through the port page. External detection logic raises the enter and leave pulses that move the flag.

Top module: `pid_page_xlat`

## Requirements
- R1: The low 12 address bits pass to `phys_addr[11:0]` unchanged. In user mode, `phys_addr[16:12]` is entry bits [4:0] of the selected table entry.
- R2: In user mode the entry is read at table index {process number (7 bits), cpu_addr[15:12]}. The same CPU page under two process numbers yields two independent entries, for up to 128 processes.
- R3: Entry bits [7:5] select the device: 000 raises `sel_ram`, 001 `sel_rom`, 010 `sel_io`, 011 `sel_pt`, and 100–111 raise none. At most one select is high.
- R4: A supervisor write (`cpu_we` high) inside the port page acts on the register chosen by cpu_addr[1:0]. 0 loads index bits [7:0]. 1 loads index bits [10:8] from data bits [2:0]. 2 stores the data byte into the table at the index. 3 loads the process number from data bits [6:0]. The effect is visible from the cycle after the write edge.
- R5: While the privilege flag is clear, writes to a page whose entry decodes as 011 change neither the table nor the process number.
- R6: While the privilege flag is set, translation ignores the table. Page 0 is RAM page 31, pages 1–12 are RAM with physical page equal to the CPU page, page 13 is the peripheral (page 0), page 14 is the table port, and page 15 is ROM page 0.
- R7: After reset the process number is 0 and the privilege flag is set.
- R8: `sup_enter` sets the flag at the next edge and `sup_exit` clears it. When both are high, the flag ends up set. With neither high, the flag holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_we | input | 1 | Write strobe for the current cycle |
| cpu_wdata | input | 8 | CPU write data |
| sup_enter | input | 1 | Pulse: enter privileged mode |
| sup_exit | input | 1 | Pulse: leave privileged mode |
| sup_active | output | 1 | Privilege flag |
| phys_addr | output | 17 | Translated physical address |
| sel_ram | output | 1 | RAM select |
| sel_rom | output | 1 | ROM select |
| sel_io | output | 1 | Peripheral select |
| sel_pt | output | 1 | Table-port select |

## Verification
Translation and device selects are combinational, so they are due in the same cycle as the address. Port writes and flag pulses take effect at the edge that samples them, and are due one cycle later. The driver changes inputs just after a rising edge and queues one expected item for that cycle. The monitor pops and compares at the following falling edge, so each comparison sees the settled result of exactly one driven cycle. Writes and flag pulses are driven for one full cycle before the next queued lookup, so every lookup already reflects them.

// File: rtl/pid_page_xlat.sv
module pid_page_xlat #(
  parameter int VA_W        = 16,
  parameter int PG_W        = 4,
  parameter int PID_W       = 7,
  parameter int PPN_W       = 5,
  parameter int DEV_W       = 3,
  parameter int SUP_LOW_PPN = 31,
  parameter int SUP_IO_PG   = 13,
  parameter int SUP_PT_PG   = 14,
  parameter int SUP_ROM_PG  = 15
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [VA_W-1:0]                 cpu_addr,
  input  logic                            cpu_we,
  input  logic [DEV_W+PPN_W-1:0]          cpu_wdata,
  input  logic                            sup_enter,
  input  logic                            sup_exit,
  output logic                            sup_active,
  output logic [PPN_W+VA_W-PG_W-1:0]      phys_addr,
  output logic                            sel_ram,
  output logic                            sel_rom,
  output logic                            sel_io,
  output logic                            sel_pt
);
  localparam int OFF_W  = VA_W - PG_W;
  localparam int ENT_W  = DEV_W + PPN_W;
  localparam int IDX_W  = PID_W + PG_W;
  localparam int IHI_W  = IDX_W - ENT_W;
  localparam int DEPTH  = 1 << IDX_W;

  localparam logic [DEV_W-1:0] DEV_RAM = DEV_W'(0);
  localparam logic [DEV_W-1:0] DEV_ROM = DEV_W'(1);
  localparam logic [DEV_W-1:0] DEV_IO  = DEV_W'(2);
  localparam logic [DEV_W-1:0] DEV_PT  = DEV_W'(3);

  localparam logic [1:0] REG_IDX_LO = 2'd0;
  localparam logic [1:0] REG_IDX_HI = 2'd1;
  localparam logic [1:0] REG_DATA   = 2'd2;
  localparam logic [1:0] REG_PID    = 2'd3;

  logic [ENT_W-1:0] tbl [DEPTH];
  logic [PID_W-1:0] pid_q;
  logic             sup_q;
  logic [ENT_W-1:0] idx_lo;
  logic [IHI_W-1:0] idx_hi;
  logic [ENT_W-1:0] sup_ent;

  wire [PG_W-1:0]  vpage    = cpu_addr[VA_W-1:OFF_W];
  wire [ENT_W-1:0] user_ent = tbl[{pid_q, vpage}];

  always_comb begin
    if (vpage == '0)
      sup_ent = {DEV_RAM, PPN_W'(SUP_LOW_PPN)};
    else if (vpage == PG_W'(SUP_IO_PG))
      sup_ent = {DEV_IO, {PPN_W{1'b0}}};
    else if (vpage == PG_W'(SUP_PT_PG))
      sup_ent = {DEV_PT, {PPN_W{1'b0}}};
    else if (vpage == PG_W'(SUP_ROM_PG))
      sup_ent = {DEV_ROM, {PPN_W{1'b0}}};
    else
      sup_ent = {DEV_RAM, PPN_W'(vpage)};
  end

  wire [ENT_W-1:0] ent = sup_q ? sup_ent : user_ent;
  wire [DEV_W-1:0] dev = ent[ENT_W-1:PPN_W];

  assign phys_addr  = {ent[PPN_W-1:0], cpu_addr[OFF_W-1:0]};
  assign sel_ram    = (dev == DEV_RAM);
  assign sel_rom    = (dev == DEV_ROM);
  assign sel_io     = (dev == DEV_IO);
  assign sel_pt     = (dev == DEV_PT);
  assign sup_active = sup_q;

  wire       port_wr = cpu_we && sup_q && sel_pt;
  wire [1:0] port_rg = cpu_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_q  <= 1'b1;
      pid_q  <= '0;
      idx_lo <= '0;
      idx_hi <= '0;
    end else begin
      if (sup_enter)     sup_q <= 1'b1;
      else if (sup_exit) sup_q <= 1'b0;
      if (port_wr) begin
        case (port_rg)
          REG_IDX_LO: idx_lo <= cpu_wdata;
          REG_IDX_HI: idx_hi <= cpu_wdata[IHI_W-1:0];
          REG_PID:    pid_q  <= cpu_wdata[PID_W-1:0];
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (port_wr && port_rg == REG_DATA)
      tbl[{idx_hi, idx_lo}] <= cpu_wdata;
  end
endmodule

module pid_page_xlat_chk #(
  parameter int VA_W        = 16,
  parameter int PG_W        = 4,
  parameter int PID_W       = 7,
  parameter int PPN_W       = 5,
  parameter int DEV_W       = 3,
  parameter int SUP_LOW_PPN = 31
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [VA_W-1:0]            cpu_addr,
  input logic                       cpu_we,
  input logic [DEV_W+PPN_W-1:0]     cpu_wdata,
  input logic                       sup_enter,
  input logic                       sup_exit,
  input logic                       sup_active,
  input logic [PPN_W+VA_W-PG_W-1:0] phys_addr,
  input logic                       sel_ram,
  input logic                       sel_rom,
  input logic                       sel_io,
  input logic                       sel_pt,
  input logic [PID_W-1:0]           pid_q
);
  localparam int OFF_W = VA_W - PG_W;

  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_pt, sel_io, sel_rom, sel_ram}));

  a_r4_pid_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_active && sel_pt && cpu_we && cpu_addr[1:0] == 2'd3)
      |=> (pid_q == $past(cpu_wdata[PID_W-1:0])));

  a_r5_user_pid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_active |=> $stable(pid_q));

  a_r6_sup_low_page: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_active && cpu_addr[VA_W-1:OFF_W] == '0)
      |-> (sel_ram && phys_addr[PPN_W+OFF_W-1:OFF_W] == PPN_W'(SUP_LOW_PPN)));

  a_r8_enter: assert property (@(posedge clk) disable iff (!rst_n)
    sup_enter |=> sup_active);

  a_r8_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_exit && !sup_enter) |=> !sup_active);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_enter && !sup_exit) |=> $stable(sup_active));
endmodule

bind pid_page_xlat pid_page_xlat_chk #(
  .VA_W(VA_W), .PG_W(PG_W), .PID_W(PID_W), .PPN_W(PPN_W),
  .DEV_W(DEV_W), .SUP_LOW_PPN(SUP_LOW_PPN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .cpu_wdata(cpu_wdata), .sup_enter(sup_enter), .sup_exit(sup_exit),
  .sup_active(sup_active), .phys_addr(phys_addr), .sel_ram(sel_ram),
  .sel_rom(sel_rom), .sel_io(sel_io), .sel_pt(sel_pt), .pid_q(pid_q)
);

// File: tb/pid_page_xlat_tb.sv
`timescale 1ns/1ps
module pid_page_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic        sup_enter = 1'b0;
  logic        sup_exit = 1'b0;
  logic        sup_active;
  logic [16:0] phys_addr;
  logic        sel_ram, sel_rom, sel_io, sel_pt;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  localparam logic [3:0] S_NONE = 4'b0000;
  localparam logic [3:0] S_RAM  = 4'b0001;
  localparam logic [3:0] S_ROM  = 4'b0010;
  localparam logic [3:0] S_IO   = 4'b0100;
  localparam logic [3:0] S_PT   = 4'b1000;

  typedef struct {
    logic [16:0] phys;
    logic [3:0]  sel;
    logic        sup;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  pid_page_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .sup_enter(sup_enter), .sup_exit(sup_exit),
    .sup_active(sup_active), .phys_addr(phys_addr), .sel_ram(sel_ram),
    .sel_rom(sel_rom), .sel_io(sel_io), .sel_pt(sel_pt)
  );

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [3:0] got_sel;
      e = sb_q.pop_front();
      got_sel = {sel_pt, sel_io, sel_rom, sel_ram};
      n_checks++;
      if (phys_addr !== e.phys || got_sel !== e.sel || sup_active !== e.sup) begin
        n_fail++;
        $display("FAIL %s: got phys=%h sel=%b sup=%b, expected phys=%h sel=%b sup=%b",
                 e.tag, phys_addr, got_sel, sup_active, e.phys, e.sel, e.sup);
      end
    end
  end

  task automatic expect_xlat(input logic [15:0] a, input logic [4:0] ppn,
                             input logic [3:0] sel, input logic sup, input string tag);
    exp_t e;
    @(posedge clk); #1;
    cpu_addr = a;
    e.phys = {ppn, a[11:0]};
    e.sel  = sel;
    e.sup  = sup;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(posedge clk); #1;
    cpu_we = 1'b0;
  endtask

  task automatic set_entry(input logic [6:0] pid, input logic [3:0] pg, input logic [7:0] ent);
    logic [10:0] idx;
    idx = {pid, pg};
    bus_write(16'hE000, idx[7:0]);
    bus_write(16'hE001, {5'd0, idx[10:8]});
    bus_write(16'hE002, ent);
  endtask

  task automatic pulse(input logic en, input logic ex);
    @(posedge clk); #1;
    sup_enter = en; sup_exit = ex;
    @(posedge clk); #1;
    sup_enter = 1'b0; sup_exit = 1'b0;
  endtask

  task automatic drain();
    @(posedge clk); @(posedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_fail++; n_checks++;
        $display("FAIL watchdog: got %0d cycles, expected under 20000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7 R6: reset state and fixed supervisor map
    expect_xlat(16'h0123, 5'd31, S_RAM, 1'b1, "R7/R6 page0 sup low");
    expect_xlat(16'hF00A, 5'd0,  S_ROM, 1'b1, "R6 rom page");
    expect_xlat(16'hD055, 5'd0,  S_IO,  1'b1, "R6 io page");
    expect_xlat(16'h5ABC, 5'd5,  S_RAM, 1'b1, "R6 identity ram");
    expect_xlat(16'hCFFF, 5'd12, S_RAM, 1'b1, "R6 top identity ram");
    expect_xlat(16'hE000, 5'd0,  S_PT,  1'b1, "R6 port page");
    drain();

    // R4: program entries for process 0 and 5
    set_entry(7'd0, 4'd0, {3'b000, 5'd3});
    set_entry(7'd0, 4'd1, {3'b001, 5'd7});
    set_entry(7'd0, 4'd2, {3'b010, 5'd9});
    set_entry(7'd0, 4'd3, {3'b011, 5'd4});
    set_entry(7'd0, 4'd4, {3'b101, 5'd2});
    set_entry(7'd5, 4'd0, {3'b000, 5'd20});
    set_entry(7'd127, 4'd15, {3'b001, 5'd17});

    pulse(1'b0, 1'b1);
    // R1 R2 R3 R7: user lookups under process 0
    expect_xlat(16'h0123, 5'd3, S_RAM,  1'b0, "R1/R7 pid0 page0 ram");
    expect_xlat(16'h1FFF, 5'd7, S_ROM,  1'b0, "R3 rom code");
    expect_xlat(16'h2000, 5'd9, S_IO,   1'b0, "R3 io code");
    expect_xlat(16'h3001, 5'd4, S_PT,   1'b0, "R3 pt code");
    expect_xlat(16'h4ABC, 5'd2, S_NONE, 1'b0, "R3 unused code");
    drain();

    // R5: user writes through a 011 page must be ignored
    bus_write(16'h3003, 8'd5);
    bus_write(16'h3000, 8'h00);
    bus_write(16'h3001, 8'h00);
    bus_write(16'h3002, {3'b001, 5'd11});
    expect_xlat(16'h0456, 5'd3, S_RAM, 1'b0, "R5 pid and entry unchanged");
    drain();

    // R8: enter and leave
    pulse(1'b1, 1'b0);
    expect_xlat(16'h0456, 5'd31, S_RAM, 1'b1, "R8 enter / R6 override");
    drain();

    // R4 R2: load process 5 and check private page 0
    bus_write(16'hE003, 8'd5);
    pulse(1'b0, 1'b1);
    expect_xlat(16'h0456, 5'd20, S_RAM, 1'b0, "R2 pid5 private page0");
    drain();

    // R8: simultaneous pulses leave the flag set
    pulse(1'b1, 1'b1);
    expect_xlat(16'h7777, 5'd7, S_RAM, 1'b1, "R8 both pulses");
    drain();

    // R2: highest process number and page
    bus_write(16'hE003, 8'd127);
    pulse(1'b0, 1'b1);
    expect_xlat(16'hF321, 5'd17, S_ROM, 1'b0, "R2 pid127 page15");
    drain();

    // R8: flag holds with no pulse
    repeat (3) @(posedge clk);
    expect_xlat(16'hF000, 5'd17, S_ROM, 1'b0, "R8 hold clear");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule